// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps subroutine and interrupt return addresses for a small processor core. A push stores the supplied program-counter value. Pushes come from call instructions, long calls and interrupt acknowledge. A pop hands the most recently stored value back, for the plain return, return-with-literal and return-from-interrupt operations. The stack has a fixed number of entries and runs as a ring. When a push is made with every slot in use, the oldest entry is overwritten without any trap. A pop with nothing stored wraps the pointer to the last slot, also without any trap.

The pointer stays inside the block and cannot be read or written. Software gets one status bit instead, the availability flag. The flag drops while the pointer sits on the last slot. Once a push carries the pointer from the last slot back to slot 0, the flag stays low until the next synchronous reset. Both the instruction decode and the program counter are outside this block.

Top module: `ret_stack`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer goes to slot 0, `avail_o` goes to 1, `ret_addr_o` goes to 0 and every slot is cleared.
- R2: A push, with `push_i`=1, writes `push_data_i` into the slot the pointer selects, then advances the pointer by one modulo DEPTH.
- R3: A pop, with `pop_i`=1 and `push_i`=0, moves the pointer back by one modulo DEPTH. The entry it then selects appears on `ret_addr_o` from the clock edge that completes the pop.
- R4: `ret_addr_o` keeps its value in every cycle without a pop. Values come back in last-in, first-out order.
- R5: The ring wraps. After DEPTH+k pushes with no pop, the first k values are overwritten. The following pops return the newest DEPTH values, newest first, and then continue around the ring.
- R6: `avail_o` is 0 in every cycle after an edge that leaves the pointer on slot DEPTH-1. If no lock has occurred, `avail_o` returns to 1 once the pointer leaves that slot.
- R7: A push made while the pointer is on slot DEPTH-1 carries the pointer to slot 0 and locks `avail_o` at 0 until reset, whatever pushes and pops follow.
- R8: A pop as the first operation after reset moves the pointer to slot DEPTH-1, so `avail_o` reads 0. A push right after it locks the flag at 0.
- R9: If `push_i` and `pop_i` are both 1 in the same cycle, only the push takes effect and `ret_addr_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Save `push_data_i` on the stack |
| pop_i | input | 1 | Restore the newest entry to `ret_addr_o` |
| push_data_i | input | WIDTH | Return address to save |
| ret_addr_o | output | WIDTH | Return address produced by the last pop |
| avail_o | output | 1 | Stack availability flag, sticky low after rollover |

## Verification
The bench builds the block with its defaults, 16 slots of 16 bits. At that size, sweeps of every push count from 0 to 20 each reach every pointer value, the last-slot flag drop, the rollover lock and overwrite by wrap. Further sweeps cover underflow pops from every depth, sequences where a pop follows underflow or a push follows it, and cycles with push and pop asserted together. After each of these sequences a reset is applied and checked. Expected return values and flag states are derived arithmetically from the ring rules, one step at a time.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    // Operation accepted in a cycle, after push-over-pop priority.
    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push_i,
    input  logic                     pop_i,
    output stk_op_e                  op_o,
    output logic [$clog2(DEPTH)-1:0] wr_idx_o,
    output logic [$clog2(DEPTH)-1:0] rd_idx_o,
    output logic                     avail_o
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          lock;
        logic          avail;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    stk_op_e     op;

    always_comb begin
        if (push_i)     op = STK_PUSH;
        else if (pop_i) op = STK_POP;
        else            op = STK_IDLE;

        st_d = st_q;
        case (op)
            STK_PUSH: begin
                st_d.ptr = st_q.ptr + 1'b1;
                if (st_q.ptr == LAST) st_d.lock = 1'b1;
            end
            STK_POP:  st_d.ptr = st_q.ptr - 1'b1;
            default:  ;
        endcase
        st_d.avail = !st_d.lock && (st_d.ptr != LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ptr   <= '0;
            st_q.lock  <= 1'b0;
            st_q.avail <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_o     = op;
    assign wr_idx_o = st_q.ptr;
    assign rd_idx_o = st_d.ptr;
    assign avail_o  = st_q.avail;

    // R2: a push moves the pointer one slot forward
    assert_push_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (push_i) |=> (st_q.ptr == PW'($past(st_q.ptr) + 1'b1)));

    // R3: a pop alone moves the pointer one slot back
    assert_pop_retreat_R3: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> (st_q.ptr == PW'($past(st_q.ptr) - 1'b1)));

    // R6: flag never high while the pointer rests on the last slot
    assert_last_slot_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (st_q.ptr == LAST) |-> !avail_o);

    // R7: once locked, the flag stays low until reset
    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q.lock) |=> (st_q.lock && !avail_o));

    // R7: a push from the last slot raises the lock
    assert_rollover_locks_R7: assert property (@(posedge clk) disable iff (rst)
        (push_i && st_q.ptr == LAST) |=> st_q.lock);
endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en_i,
    input  logic [$clog2(DEPTH)-1:0] wr_idx_i,
    input  logic [WIDTH-1:0]         wr_data_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [WIDTH-1:0]         rd_data_o
);
    logic [WIDTH-1:0] slot_d [DEPTH];
    logic [WIDTH-1:0] slot_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en_i) slot_d[wr_idx_i] = wr_data_i;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) slot_q[i] <= '0;
            else     slot_q[i] <= slot_d[i];
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];

    // R2: a written slot holds the pushed data on the next cycle
    assert_slot_written_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i) |=> (slot_q[$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic [WIDTH-1:0] ret_addr_o,
    output logic             avail_o
);
    localparam int PW = $clog2(DEPTH);

    stk_op_e          op;
    logic [PW-1:0]    wr_idx;
    logic [PW-1:0]    rd_idx;
    logic [WIDTH-1:0] rd_data;
    logic [WIDTH-1:0] ret_d, ret_q;

    ret_stack_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .op_o     (op),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .avail_o  (avail_o)
    );

    ret_stack_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) mem_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (op == STK_PUSH),
        .wr_idx_i  (wr_idx),
        .wr_data_i (push_data_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    always_comb begin
        ret_d = ret_q;
        if (op == STK_POP) ret_d = rd_data;
    end

    always_ff @(posedge clk) begin
        if (rst) ret_q <= '0;
        else     ret_q <= ret_d;
    end

    assign ret_addr_o = ret_q;

    // R4: the return output only changes on a pop alone
    assert_ret_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!(pop_i && !push_i)) |=> $stable(ret_addr_o));

    // R9: push and pop together leave the return output alone
    assert_push_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |=> $stable(ret_addr_o));
endmodule

// File: tb/ret_stack_tb_top.sv
`timescale 1ns/1ps
module ret_stack_tb_top;
    localparam int DEPTH = 16;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push = 1'b0;
    logic             pop = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] ret;
    logic             avail;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    int         m_ptr;
    bit         m_lock;
    logic [WIDTH-1:0] m_slot [DEPTH];
    logic [WIDTH-1:0] m_ret;

    always #2 clk = ~clk;

    ret_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (din),
        .ret_addr_o  (ret),
        .avail_o     (avail)
    );

    task automatic check(input string tag, input logic [WIDTH-1:0] act,
                         input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_avail();
        return !m_lock && (m_ptr != DEPTH - 1);
    endfunction

    task automatic compare(input string tag);
        check({tag, " ret"}, ret, m_ret);
        check({tag, " avail"}, {{(WIDTH-1){1'b0}}, avail},
              {{(WIDTH-1){1'b0}}, m_avail()});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; push = 0; pop = 0;
        @(negedge clk);
        rst = 1'b0;
        m_ptr = 0; m_lock = 0; m_ret = '0;
        for (int i = 0; i < DEPTH; i++) m_slot[i] = '0;
        compare("R1 reset");
    endtask

    task automatic step(input bit pu, input bit po, input logic [WIDTH-1:0] d,
                        input string tag);
        push = pu; pop = po; din = d;
        @(negedge clk);
        push = 0; pop = 0;
        if (pu) begin
            m_slot[m_ptr] = d;
            if (m_ptr == DEPTH - 1) m_lock = 1;
            m_ptr = (m_ptr + 1) % DEPTH;
        end else if (po) begin
            m_ptr = (m_ptr + DEPTH - 1) % DEPTH;
            m_ret = m_slot[m_ptr];
        end
        compare(tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2 R3 R4 R5 R6 R7: push n values, then pop them all
        for (int n = 0; n <= DEPTH + 4; n++) begin
            do_reset();
            for (int i = 0; i < n; i++)
                step(1, 0, WIDTH'(16'hA000 + n * 32 + i),
                     (i == DEPTH - 1) ? "R7 rollover push" : "R2 push");
            if (n == DEPTH - 1) check("R6 last slot flag", {15'd0, avail}, 16'd0);
            for (int k = 0; k < n; k++)
                step(0, 1, '0, (n > DEPTH) ? "R5 wrap pop" : "R3 pop");
            step(0, 0, '0, "R4 hold");
        end

        // R8: pop first after reset, then a push locks
        do_reset();
        step(0, 1, '0, "R8 underflow pop");
        check("R8 flag low", {15'd0, avail}, 16'd0);
        step(1, 0, 16'h1234, "R8 push after underflow");
        step(0, 1, '0, "R8 locked after pop");
        check("R8 still locked", {15'd0, avail}, 16'd0);

        // R6: underflow then pop again releases the flag (no lock)
        do_reset();
        step(0, 1, '0, "R6 underflow");
        step(0, 1, '0, "R6 leave last slot");
        check("R6 flag back", {15'd0, avail}, 16'd1);

        // R8 R3: underflow pops from every depth
        for (int n = 0; n < DEPTH; n++) begin
            do_reset();
            for (int i = 0; i < n; i++) step(1, 0, WIDTH'(16'h5000 + i), "R2 fill");
            for (int k = 0; k <= n + 2; k++) step(0, 1, '0, "R8 deep pop");
        end

        // R9: push and pop together
        do_reset();
        step(1, 0, 16'hBEEF, "R2 push");
        step(0, 1, '0, "R3 pop");
        step(1, 0, 16'hCAFE, "R2 push");
        step(1, 1, 16'hD00D, "R9 push wins");
        check("R9 ret unchanged", ret, 16'hBEEF);
        step(0, 1, '0, "R9 pop after both");
        check("R9 pushed data", ret, 16'hD00D);

        // R1: reset after lock restores the flag
        do_reset();
        for (int i = 0; i < DEPTH + 1; i++) step(1, 0, WIDTH'(i), "R7 lock");
        check("R7 locked", {15'd0, avail}, 16'd0);
        do_reset();
        check("R1 flag after lock", {15'd0, avail}, 16'd1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule